// File: doc/BRIEF.md
# Uncorrectable Error Header Log Queue

This block keeps the logging state that an advanced-error-reporting function holds for uncorrectable errors. It owns the uncorrectable status vector, a 5-bit pointer to the first error, a four-dword header log and a four-dword prefix log with a present flag. Error records come in one per cycle. Each record carries a one-hot status vector, a header-valid flag, a prefix-present flag, and the header and prefix words. Software clears of status bits arrive as a write-one-to-clear mask, and a separate strobe marks any write to the capability/control register.

When several-header recording is enabled and the first error is still unacknowledged, later errors wait in a small queue and the visible log stays as it is. When software clears the first error bit, the block refills the log from the queue head and sets the status bits of every waiting record again. While the first error stays set, a software clear of any bit that belongs to a queued record is undone. A record that finds the queue full is dropped and a header-log-overflow pulse is raised for the correctable-error logic.

Every output is registered and changes one clock after the input that causes it. A record must not share a cycle with a status clear or a capability write.

Top module: `uerr_log_queue`

## Requirements
- R1: A record whose status vector has zero bits set or more than one bit set is rejected. `rec_reject` is high for exactly the following cycle, and no other output changes.
- R2: An accepted record sets its own bit in `uncor_status`. This holds whether the record is logged, queued or dropped.
- R3: A record is logged when recording is disabled or the status bit at `first_err_ptr` is clear. Logging sets `first_err_ptr` to the index of the record's status bit.
- R4: On logging, header dword i (input bits [32i+31:32i]) is stored at the same position in `hdr_log` with its four bytes reversed, so that input byte 0 lands in the top byte. When the header-valid flag is low, `hdr_log` is cleared to zero.
- R5: On logging, `pfx_log_present` is set and the prefix dwords are stored byte-reversed like the header only when the record's prefix flag and `cfg_pfx_en` are both high. Otherwise both `pfx_log` and the flag are cleared.
- R6: When recording is enabled and the status bit at `first_err_ptr` is set, an accepted record is pushed into the queue. `queue_count` rises by one and the visible log does not change.
- R7: A record that would be pushed while `queue_count` equals `Q_DEPTH` (a parameter from 1 to 32) is dropped. `hlo_pulse` is high for one cycle and `queue_count` is unchanged.
- R8: When a status clear leaves the bit at `first_err_ptr` clear, and recording is disabled or the queue is empty, the block clears the pointer, `pfx_log_present`, `hdr_log` and `pfx_log` to zero.
- R9: When a status clear leaves the first error bit clear while recording is enabled and the queue holds records, the status bits of all queued records (head included) are set again, and the head is popped and logged as in R3 to R5.
- R10: When a status clear leaves the first error bit set, the clear takes effect except on bits that belong to queued records, which are set again while recording is enabled. With recording disabled, a clear simply clears the masked bits.
- R11: A capability/control write empties the queue, so `queue_count` reads zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mhr_en | input | 1 | Several-header recording enable |
| cfg_pfx_en | input | 1 | End-to-end prefix support enable |
| rec_valid | input | 1 | Error record strobe |
| rec_status | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr_valid | input | 1 | Header words are meaningful |
| rec_pfx_present | input | 1 | Record carries prefix words |
| rec_hdr | input | 128 | Header dwords, dword i at bits 32i+31:32i |
| rec_pfx | input | 128 | Prefix dwords, same packing |
| sts_clr_valid | input | 1 | Software status clear strobe |
| sts_clr_mask | input | 32 | Write-one-to-clear mask |
| cap_wr | input | 1 | Write to capability/control register |
| uncor_status | output | 32 | Uncorrectable status vector |
| first_err_ptr | output | 5 | Index of the first logged error |
| hdr_log | output | 128 | Header log, byte-reversed dwords |
| pfx_log | output | 128 | Prefix log, byte-reversed dwords |
| pfx_log_present | output | 1 | Prefix log holds a prefix |
| hlo_pulse | output | 1 | Header log overflow, one cycle |
| rec_reject | output | 1 | Malformed record, one cycle |
| queue_count | output | $clog2(Q_DEPTH+1) | Records waiting in the queue |

## Verification
The bench targets the points where the first error bit decides between logging and queueing, and where a clear decides among wipe, reload and revert. A design that tested the bit after the new record's update would queue the very first error. A design that forgot to reassert queued bits on reload would lose pending errors from `uncor_status`. The bench also fills the queue to its depth and one record past it, which catches an off-by-one that either drops early or overwrites the head. Finally, it sweeps all 32 status bits with varied header and prefix flags, which catches index encoding and byte order faults, and it checks that malformed records and a flushed queue leave no trace.

// File: rtl/ulq_pkg.sv
package ulq_pkg;
  localparam int STS_W = 32;
  localparam int IDX_W = $clog2(STS_W);
  localparam int NDW   = 4;
  localparam int LOG_W = 32 * NDW;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             hdr_ok;
    logic             pfx_ok;
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
  } ulq_rec_t;

  // Reverse the bytes inside each dword, keeping dword positions.
  function automatic logic [LOG_W-1:0] dw_byterev(input logic [LOG_W-1:0] w);
    logic [LOG_W-1:0] r;
    r = '0;
    for (int d = 0; d < NDW; d++) begin
      for (int b = 0; b < 4; b++) begin
        r[d*32 + b*8 +: 8] = w[d*32 + (3-b)*8 +: 8];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ulq_onehot.sv
module ulq_onehot
  import ulq_pkg::*;
(
  input  logic [STS_W-1:0] vec,
  output logic             ok,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0] ones;

  always_comb begin
    ones = '0;
    idx  = '0;
    for (int i = 0; i < STS_W; i++) begin
      ones = ones + {{IDX_W{1'b0}}, vec[i]};
      if (vec[i]) idx = IDX_W'(i);
    end
    ok = (ones == (IDX_W+1)'(1));
  end
endmodule

// File: rtl/ulq_queue.sv
module ulq_queue
  import ulq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  ulq_rec_t         push_rec,
  output ulq_rec_t         head_rec,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic [STS_W-1:0] queued_mask
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ulq_rec_t         mem   [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    wr_p, rd_p;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Payload storage: no reset, single write port.
  always_ff @(posedge clk) begin
    if (push && !flush) begin
      mem[wr_p]   <= push_rec;
      idx_q[wr_p] <= push_rec.idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
      vld  <= '0;
    end else begin
      if (push) begin
        vld[wr_p] <= 1'b1;
        wr_p      <= step(wr_p);
      end
      if (pop) begin
        vld[rd_p] <= 1'b0;
        rd_p      <= step(rd_p);
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    queued_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) queued_mask[idx_q[i]] = 1'b1;
    end
  end

  assign head_rec = mem[rd_p];
  assign count    = cnt;
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R6
  valid_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) == int'(cnt));
endmodule

// File: rtl/uerr_log_queue.sv
module uerr_log_queue
  import ulq_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  localparam int QCW = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mhr_en,
  input  logic             cfg_pfx_en,
  input  logic             rec_valid,
  input  logic [STS_W-1:0] rec_status,
  input  logic             rec_hdr_valid,
  input  logic             rec_pfx_present,
  input  logic [LOG_W-1:0] rec_hdr,
  input  logic [LOG_W-1:0] rec_pfx,
  input  logic             sts_clr_valid,
  input  logic [STS_W-1:0] sts_clr_mask,
  input  logic             cap_wr,
  output logic [STS_W-1:0] uncor_status,
  output logic [IDX_W-1:0] first_err_ptr,
  output logic [LOG_W-1:0] hdr_log,
  output logic [LOG_W-1:0] pfx_log,
  output logic             pfx_log_present,
  output logic             hlo_pulse,
  output logic             rec_reject,
  output logic [QCW-1:0]   queue_count
);
  logic             rec_ok;
  logic [IDX_W-1:0] rec_idx;
  ulq_rec_t         in_rec, q_head, src;
  logic             q_full, q_empty;
  logic [STS_W-1:0] q_mask;

  logic [STS_W-1:0] sts_q, sts_left;
  logic [IDX_W-1:0] fep_q;
  logic             first_set, rec_go, rec_hold, do_push, do_drop, do_take;
  logic             fe_gone, do_pop, do_wipe, keep_q;

  ulq_onehot u_dec (
    .vec (rec_status),
    .ok  (rec_ok),
    .idx (rec_idx)
  );

  assign in_rec = '{idx: rec_idx, hdr_ok: rec_hdr_valid, pfx_ok: rec_pfx_present,
                    hdr: rec_hdr, pfx: rec_pfx};

  ulq_queue #(.DEPTH(Q_DEPTH)) u_q (
    .clk         (clk),
    .rst         (rst),
    .push        (do_push),
    .pop         (do_pop),
    .flush       (cap_wr),
    .push_rec    (in_rec),
    .head_rec    (q_head),
    .count       (queue_count),
    .full        (q_full),
    .empty       (q_empty),
    .queued_mask (q_mask)
  );

  always_comb begin
    first_set = sts_q[fep_q];
    rec_go    = rec_valid && rec_ok;
    rec_hold  = rec_go && cfg_mhr_en && first_set;
    do_push   = rec_hold && !q_full && !cap_wr;
    do_drop   = rec_hold && q_full;
    do_take   = rec_go && !rec_hold;
    sts_left  = sts_q & ~sts_clr_mask;
    fe_gone   = sts_clr_valid && !sts_left[fep_q];
    do_pop    = fe_gone && cfg_mhr_en && !q_empty && !cap_wr;
    do_wipe   = fe_gone && !do_pop;
    keep_q    = sts_clr_valid && cfg_mhr_en && !cap_wr && (do_pop || !fe_gone);
    src       = do_pop ? q_head : in_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q           <= '0;
      fep_q           <= '0;
      hdr_log         <= '0;
      pfx_log         <= '0;
      pfx_log_present <= 1'b0;
      hlo_pulse       <= 1'b0;
      rec_reject      <= 1'b0;
    end else begin
      rec_reject <= rec_valid && !rec_ok;
      hlo_pulse  <= do_drop;
      if (rec_go)
        sts_q <= sts_q | rec_status;
      else if (sts_clr_valid)
        sts_q <= keep_q ? (sts_left | q_mask) : sts_left;
      if (do_take || do_pop) begin
        fep_q           <= src.idx;
        hdr_log         <= src.hdr_ok ? dw_byterev(src.hdr) : '0;
        pfx_log_present <= src.pfx_ok && cfg_pfx_en;
        pfx_log         <= (src.pfx_ok && cfg_pfx_en) ? dw_byterev(src.pfx) : '0;
      end else if (do_wipe) begin
        fep_q           <= '0;
        hdr_log         <= '0;
        pfx_log         <= '0;
        pfx_log_present <= 1'b0;
      end
    end
  end

  assign uncor_status  = sts_q;
  assign first_err_ptr = fep_q;

  // R1
  bad_rec_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && $countones(rec_status) != 1
      |=> rec_reject && $stable(uncor_status) && $stable(first_err_ptr) && $stable(hdr_log));
  // R3
  take_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && $countones(rec_status) == 1 && !(cfg_mhr_en && uncor_status[first_err_ptr])
      |=> uncor_status[first_err_ptr] && first_err_ptr == $past(rec_idx));
  // R7
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && $countones(rec_status) == 1 && cfg_mhr_en && uncor_status[first_err_ptr]
      && queue_count == QCW'(Q_DEPTH) && !cap_wr
      |=> hlo_pulse && $stable(queue_count));
  // R5
  pfx_rose_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pfx_log_present) |-> $past(cfg_pfx_en));
  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    cap_wr |=> queue_count == '0);
  // R6
  hold_log_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && $countones(rec_status) == 1 && cfg_mhr_en && uncor_status[first_err_ptr]
      |=> $stable(first_err_ptr) && $stable(hdr_log) && $stable(pfx_log));
endmodule

// File: tb/tb_uerr_log_queue.sv
module tb_uerr_log_queue;
  localparam int QD = 4;
  localparam int QCW = $clog2(QD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mhr_en = 1'b0, cfg_pfx_en = 1'b0;
  logic rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
  logic [31:0] rec_status = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic sts_clr_valid = 1'b0, cap_wr = 1'b0;
  logic [31:0] sts_clr_mask = '0;
  logic [31:0] uncor_status;
  logic [4:0] first_err_ptr;
  logic [127:0] hdr_log, pfx_log;
  logic pfx_log_present, hlo_pulse, rec_reject;
  logic [QCW-1:0] queue_count;

  always #4 clk = ~clk;

  uerr_log_queue #(.Q_DEPTH(QD)) dut (
    .clk(clk), .rst(rst), .cfg_mhr_en(cfg_mhr_en), .cfg_pfx_en(cfg_pfx_en),
    .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
    .rec_pfx_present(rec_pfx_present), .rec_hdr(rec_hdr), .rec_pfx(rec_pfx),
    .sts_clr_valid(sts_clr_valid), .sts_clr_mask(sts_clr_mask), .cap_wr(cap_wr),
    .uncor_status(uncor_status), .first_err_ptr(first_err_ptr), .hdr_log(hdr_log),
    .pfx_log(pfx_log), .pfx_log_present(pfx_log_present), .hlo_pulse(hlo_pulse),
    .rec_reject(rec_reject), .queue_count(queue_count)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Reference state
  logic [31:0] e_sts = '0;
  logic [4:0] e_fep = '0;
  logic [127:0] e_hdr = '0, e_pfx = '0;
  logic e_pp = 0, e_hlo = 0, e_rej = 0, e_mhr = 0, e_pfxen = 0;
  int qn = 0;
  logic [4:0] q_idx [QD];
  logic q_hv [QD], q_pp [QD];
  logic [127:0] q_h [QD], q_p [QD];

  function automatic logic [127:0] swp(input logic [127:0] w);
    logic [127:0] r;
    for (int d = 0; d < 4; d++) begin
      logic [31:0] x;
      x = w[d*32 +: 32];
      r[d*32 +: 32] = {x[7:0], x[15:8], x[23:16], x[31:24]};
    end
    return r;
  endfunction

  task automatic chk(string req, string ctx, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  task automatic cmp_all(string ctx);
    chk("R2", ctx, 128'(uncor_status), 128'(e_sts));
    chk("R3", ctx, 128'(first_err_ptr), 128'(e_fep));
    chk("R4", ctx, hdr_log, e_hdr);
    chk("R5", ctx, pfx_log, e_pfx);
    chk("R5", ctx, 128'(pfx_log_present), 128'(e_pp));
    chk("R7", ctx, 128'(hlo_pulse), 128'(e_hlo));
    chk("R1", ctx, 128'(rec_reject), 128'(e_rej));
    chk("R6", ctx, 128'(queue_count), 128'(qn));
    e_hlo = 0;
    e_rej = 0;
  endtask

  task automatic m_load(logic [4:0] i, logic hv, logic pp, logic [127:0] h, logic [127:0] p);
    e_fep = i;
    e_hdr = hv ? swp(h) : '0;
    e_pp  = pp && e_pfxen;
    e_pfx = e_pp ? swp(p) : '0;
  endtask

  function automatic logic [31:0] qmask();
    logic [31:0] m = '0;
    for (int k = 0; k < qn; k++) m[q_idx[k]] = 1'b1;
    return m;
  endfunction

  task automatic do_rec(logic [31:0] s, logic hv, logic pp, logic [127:0] h, logic [127:0] p, string ctx);
    @(negedge clk);
    rec_valid = 1; rec_status = s; rec_hdr_valid = hv; rec_pfx_present = pp;
    rec_hdr = h; rec_pfx = p;
    if ($countones(s) != 1) e_rej = 1;
    else begin
      logic [4:0] ix = '0;
      for (int k = 0; k < 32; k++) if (s[k]) ix = 5'(k);
      if (e_mhr && e_sts[e_fep]) begin
        if (qn < QD) begin
          q_idx[qn] = ix; q_hv[qn] = hv; q_pp[qn] = pp; q_h[qn] = h; q_p[qn] = p;
          qn++;
        end else e_hlo = 1;
      end else m_load(ix, hv, pp, h, p);
      e_sts = e_sts | s;
    end
    @(negedge clk);
    rec_valid = 0;
    cmp_all(ctx);
  endtask

  task automatic do_clr(logic [31:0] m, string ctx);
    logic [31:0] left;
    @(negedge clk);
    sts_clr_valid = 1; sts_clr_mask = m;
    left = e_sts & ~m;
    if (!left[e_fep]) begin
      if (!e_mhr || qn == 0) begin
        e_sts = left; e_fep = '0; e_hdr = '0; e_pfx = '0; e_pp = 0;
      end else begin
        e_sts = left | qmask();
        m_load(q_idx[0], q_hv[0], q_pp[0], q_h[0], q_p[0]);
        for (int k = 0; k < QD - 1; k++) begin
          q_idx[k] = q_idx[k+1]; q_hv[k] = q_hv[k+1]; q_pp[k] = q_pp[k+1];
          q_h[k] = q_h[k+1]; q_p[k] = q_p[k+1];
        end
        qn--;
      end
    end else e_sts = e_mhr ? (left | qmask()) : left;
    @(negedge clk);
    sts_clr_valid = 0;
    cmp_all(ctx);
  endtask

  task automatic do_cap(logic mhr, logic pfxen, string ctx);
    @(negedge clk);
    cap_wr = 1; cfg_mhr_en = mhr; cfg_pfx_en = pfxen;
    e_mhr = mhr; e_pfxen = pfxen; qn = 0;
    @(negedge clk);
    cap_wr = 0;
    cmp_all(ctx);
  endtask

  function automatic logic [127:0] pat(int i, int salt);
    logic [127:0] v;
    for (int d = 0; d < 4; d++)
      v[d*32 +: 32] = 32'h01020304 * (i + 1) + 32'(d * 32'h11111111) + 32'(salt);
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp_all("R8 reset state");

    // Sweep every status bit with recording off
    for (int i = 0; i < 32; i++) begin
      cfg_pfx_en = i[1]; e_pfxen = i[1];
      do_rec(32'h1 << i, i[0], (i % 3) == 0, pat(i, 0), pat(i, 7), "R3 sweep log");
      do_rec(32'h1 << ((i + 5) % 32), ~i[0], 1'b1, pat(i, 3), pat(i, 9), "R3 overwrite no recording");
      do_clr(32'h1 << ((i + 5) % 32), "R8 wipe");
      do_clr(32'h1 << i, "R10 plain clear");
    end

    // Malformed records
    do_rec(32'h0000_0002, 1, 1, pat(1, 1), pat(1, 2), "R3 setup");
    do_rec(32'h0, 1, 1, pat(2, 1), pat(2, 2), "R1 zero bits");
    do_rec(32'h3, 1, 1, pat(3, 1), pat(3, 2), "R1 two bits");
    do_rec(32'h8000_0001, 0, 0, pat(4, 1), pat(4, 2), "R1 far bits");
    do_rec(32'hFFFF_FFFF, 0, 0, pat(5, 1), pat(5, 2), "R1 all bits");
    do_clr(32'h2, "R8 wipe after reject");

    // Queueing with recording on
    do_cap(1, 1, "R11 enable");
    do_rec(32'h1 << 4, 1, 1, pat(10, 0), pat(10, 1), "R3 first error");
    do_rec(32'h1 << 7, 1, 0, pat(11, 0), pat(11, 1), "R6 queue");
    do_rec(32'h1 << 9, 0, 1, pat(12, 0), pat(12, 1), "R6 queue");
    do_rec(32'h1 << 11, 1, 1, pat(13, 0), pat(13, 1), "R6 queue");
    do_rec(32'h1 << 13, 0, 0, pat(14, 0), pat(14, 1), "R6 queue full");
    do_rec(32'h1 << 15, 1, 1, pat(15, 0), pat(15, 1), "R7 overflow");
    do_rec(32'h1 << 17, 1, 1, pat(16, 0), pat(16, 1), "R7 overflow again");
    do_clr(32'h1 << 9, "R10 revert queued bit");
    do_clr((32'h1 << 15) | (32'h1 << 13), "R10 partial revert");
    do_clr(32'h1 << 4, "R9 reload head");
    do_rec(32'h1 << 20, 1, 1, pat(17, 0), pat(17, 1), "R6 queue after pop");
    do_clr(32'h1 << 7, "R9 reload second");
    do_clr((32'h1 << 9) | (32'h1 << 11), "R9 reload with revert");
    do_cap(0, 1, "R11 flush");
    do_cap(1, 1, "R11 flush empty");
    do_clr(32'hFFFF_FFFF, "R8 wipe with empty queue");

    // Prefix gating with recording on and queue reload under prefix disabled
    do_rec(32'h1 << 1, 1, 1, pat(20, 0), pat(20, 1), "R5 prefix on");
    do_rec(32'h1 << 2, 1, 1, pat(21, 0), pat(21, 1), "R6 queue prefix");
    @(negedge clk); cfg_pfx_en = 0; e_pfxen = 0;
    do_clr(32'h1 << 1, "R5 reload with prefix off");
    do_clr(32'h1 << 2, "R8 final wipe");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule